// File: doc/BRIEF.md
# Soft-Ramp Stereo Output Volume

This block scales a stereo stream of signed samples by a gain chosen with an 8-bit volume code. The gain rises by half a decibel for each code step. Code 18h gives unity gain, and every code below 18h lowers the gain. The block never jumps straight to a newly programmed code. It keeps an applied code for each channel. While the converter power input is low, that code stays at unity. Once power is high, the code moves one step toward the programmed code on each sample strobe, which gives a click-free fade.

When the link control is high, the left volume code sets the target for both channels. When it is low, each channel follows its own code. Each strobe presents one left/right sample pair. The scaled pair appears on the cycle after the strobe, together with a one-cycle valid pulse. Products are rounded and clipped to the sample width.

Top module: `softramp_volume`

## Requirements
- R1: After reset, both outputs are zero, the valid output is low, and both applied codes are 18h (unity gain).
- R2: For an applied code c in 00h..3Ch, the gain is 2^(floor(c/12)-2) * M[c mod 12] / 16384, where M[r] = round(16384 * 10^(r/40)). This makes 18h unity, 28h +8 dB, and each code step 0.5 dB.
- R3: While the power input is low, the applied codes of both channels are held at 18h whatever the volume codes are. Dropping power during a ramp returns the gain to unity from the next clock.
- R4: While power is high, each sample strobe moves each applied code one step toward its target, upward or downward. The code stops once it equals the target.
- R5: Without a strobe, the applied codes do not change.
- R6: With the link input high, the right channel targets the left volume code. With it low, the right channel targets the right volume code.
- R7: The outputs update on the clock after a strobe, using the applied code in force before that strobe's step. The valid output pulses for that one cycle, and the outputs hold between strobes.
- R8: A scaled value is rounded half toward plus infinity: 2^(s-1) is added before an arithmetic right shift by s = 16 - floor(c/12). The result is then clipped to the signed sample range.
- R9: A volume code above 3Ch is treated as 3Ch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_stb | input | 1 | One-cycle strobe marking a new sample pair |
| dac_pwr | input | 1 | Converter power; high enables ramping |
| link_lr | input | 1 | High: left code controls both channels |
| vol_code_l | input | 8 | Left (or shared) volume code |
| vol_code_r | input | 8 | Right volume code |
| din_l | input | 16 | Left signed input sample |
| din_r | input | 16 | Right signed input sample |
| dout_l | output | 16 | Left scaled sample |
| dout_r | output | 16 | Right scaled sample |
| dout_valid | output | 1 | Pulses the cycle after a strobe |

## Verification
The scaling is tried with a constant large sample through a complete upward ramp and a complete downward ramp. Because each strobe's output reveals the applied code, these runs tell a correct one-step ramp apart from a jump, an overshoot or an early stop. Small odd and negative samples at the lowest code separate round-half-up from truncation. Near-full-scale inputs at the top code exercise both clip limits. Separate left and right codes, run with the link on and off, separate shared from independent targets, and dropping power mid-ramp shows the fall back to unity.

// File: rtl/vol_pkg.sv
// Package: shared constants and the per-half-decibel mantissa table.
// Assumes the default code is a multiple of the codes-per-octave count.
package vol_pkg;
    localparam int CODE_W     = 8;
    localparam int FRAC_W     = 14;
    localparam int MANT_W     = 16;
    localparam int OCT_STEPS  = 12;
    localparam logic [CODE_W-1:0] CODE_UNITY = 8'h18;
    localparam logic [CODE_W-1:0] CODE_TOP   = 8'h3C;

    // Mantissa for a fractional-octave index r: round(2^14 * 10^(r/40)).
    function automatic logic [MANT_W-1:0] mant_of(input logic [3:0] r);
        case (r)
            4'd0:    mant_of = 16'd16384;
            4'd1:    mant_of = 16'd17355;
            4'd2:    mant_of = 16'd18383;
            4'd3:    mant_of = 16'd19472;
            4'd4:    mant_of = 16'd20626;
            4'd5:    mant_of = 16'd21848;
            4'd6:    mant_of = 16'd23143;
            4'd7:    mant_of = 16'd24514;
            4'd8:    mant_of = 16'd25967;
            4'd9:    mant_of = 16'd27506;
            4'd10:   mant_of = 16'd29135;
            4'd11:   mant_of = 16'd30862;
            default: mant_of = 16'd16384;
        endcase
    endfunction
endpackage

// File: rtl/vol_ramp.sv
// Module: per-channel applied-code ramp. Holds the unity code while power
// is low and steps one code toward a clamped target on each strobe.
// Assumes the target may be any 8-bit value; values above CODE_MAX are clamped.
module vol_ramp #(
    parameter int CODE_W = 8,
    parameter logic [CODE_W-1:0] CODE_DEF = 8'h18,
    parameter logic [CODE_W-1:0] CODE_MAX = 8'h3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr,
    input  logic              stb,
    input  logic [CODE_W-1:0] target_raw,
    output logic [CODE_W-1:0] code
);
    logic [CODE_W-1:0] tgt;

    // Clamp the requested code to the supported top of the range.
    always_comb tgt = (target_raw > CODE_MAX) ? CODE_MAX : target_raw;

    // Hold at default without power; otherwise step toward target per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)          code <= CODE_DEF;
        else if (!pwr)       code <= CODE_DEF;
        else if (stb) begin
            if (code < tgt)      code <= code + 1'b1;
            else if (code > tgt) code <= code - 1'b1;
        end
    end

    AST_HOLD_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr |=> code == CODE_DEF); // R3
    AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr && !stb) |=> $stable(code)); // R5
    AST_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr && stb && code == tgt) |=> $stable(code)); // R4
    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr && stb && code < tgt) |=> code == $past(code) + 1'b1); // R4
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr && stb && code > tgt) |=> code == $past(code) - 1'b1); // R4
endmodule

// File: rtl/vol_gain.sv
// Module: combinational code-to-gain scaler. Splits the code into octave and
// fraction, multiplies by the mantissa, rounds half up, shifts, and clips.
// Assumes code <= CODE_MAX so the shift amount stays positive.
module vol_gain
    import vol_pkg::*;
#(
    parameter int W = 16,
    parameter int CW = 8,
    parameter logic [CW-1:0] CODE_DEF = 8'h18
) (
    input  logic [CW-1:0]       code,
    input  logic signed [W-1:0] x,
    output logic signed [W-1:0] y
);
    localparam int PW       = W + MANT_W + 1;
    localparam int OCT_BIAS = int'(CODE_DEF) / OCT_STEPS;
    localparam logic signed [PW-1:0] YMAX = PW'((64'sd1 <<< (W - 1)) - 1);
    localparam logic signed [PW-1:0] YMIN = -PW'(64'sd1 <<< (W - 1));

    logic [CW-1:0]              oct_idx;
    logic [CW-1:0]              frac_idx;
    logic [MANT_W-1:0]          mant;
    logic [5:0]                 shamt;
    logic signed [PW-1:0]       prod;
    logic signed [PW-1:0]       biased;
    logic signed [PW-1:0]       shifted;

    // Split the code into octave count and half-decibel index.
    always_comb begin
        oct_idx  = code / CW'(OCT_STEPS);
        frac_idx = code % CW'(OCT_STEPS);
        mant     = mant_of(frac_idx[3:0]);
        shamt    = 6'(FRAC_W + OCT_BIAS) - oct_idx[5:0];
    end

    // Multiply, round half up, shift, and clip to the sample width.
    always_comb begin
        prod    = PW'(x) * $signed({1'b0, mant});
        biased  = prod + (PW'(1) <<< (shamt - 6'd1));
        shifted = biased >>> shamt;
        if (shifted > YMAX)      y = YMAX[W-1:0];
        else if (shifted < YMIN) y = YMIN[W-1:0];
        else                     y = shifted[W-1:0];
    end
endmodule

// File: rtl/softramp_volume.sv
// Module: stereo soft-ramp volume top. Chooses per-channel targets (linked
// or independent), ramps each applied code, scales samples and registers them.
// Assumes sample_stb is a single-cycle pulse per sample pair.
module softramp_volume
    import vol_pkg::*;
#(
    parameter int W = 16,
    parameter int CW = 8,
    parameter logic [CW-1:0] CODE_DEF = 8'h18,
    parameter logic [CW-1:0] CODE_MAX = 8'h3C
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_stb,
    input  logic                dac_pwr,
    input  logic                link_lr,
    input  logic [CW-1:0]       vol_code_l,
    input  logic [CW-1:0]       vol_code_r,
    input  logic signed [W-1:0] din_l,
    input  logic signed [W-1:0] din_r,
    output logic signed [W-1:0] dout_l,
    output logic signed [W-1:0] dout_r,
    output logic                dout_valid
);
    localparam int NCH = 2;

    logic [CW-1:0]       tgt  [NCH];
    logic [CW-1:0]       code [NCH];
    logic signed [W-1:0] din  [NCH];
    logic signed [W-1:0] scl  [NCH];
    logic signed [W-1:0] dq   [NCH];

    // Route targets: right follows left when linked.
    always_comb begin
        tgt[0] = vol_code_l;
        tgt[1] = link_lr ? vol_code_l : vol_code_r;
        din[0] = din_l;
        din[1] = din_r;
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        vol_ramp #(.CODE_W(CW), .CODE_DEF(CODE_DEF), .CODE_MAX(CODE_MAX)) u_ramp (
            .clk(clk), .rst_n(rst_n), .pwr(dac_pwr), .stb(sample_stb),
            .target_raw(tgt[ch]), .code(code[ch])
        );
        vol_gain #(.W(W), .CW(CW), .CODE_DEF(CODE_DEF)) u_gain (
            .code(code[ch]), .x(din[ch]), .y(scl[ch])
        );

        // Capture the scaled sample on each strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)          dq[ch] <= '0;
            else if (sample_stb) dq[ch] <= scl[ch];
        end
    end

    // Pulse valid one cycle after each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) dout_valid <= 1'b0;
        else        dout_valid <= sample_stb;
    end

    assign dout_l = dq[0];
    assign dout_r = dq[1];

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> dout_valid); // R7
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |=> !dout_valid); // R7
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |=> ($stable(dout_l) && $stable(dout_r))); // R7
endmodule

// File: tb/softramp_volume_test.sv
module softramp_volume_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_stb = 1'b0;
    logic dac_pwr = 1'b0;
    logic link_lr = 1'b1;
    logic [7:0] vol_code_l = 8'h18;
    logic [7:0] vol_code_r = 8'h18;
    logic signed [15:0] din_l = '0;
    logic signed [15:0] din_r = '0;
    logic signed [15:0] dout_l;
    logic signed [15:0] dout_r;
    logic dout_valid;

    int n_checks = 0;
    int n_fails = 0;
    int cur_l = 24;
    int cur_r = 24;

    always #5 clk = ~clk;

    softramp_volume uut (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .dac_pwr(dac_pwr),
        .link_lr(link_lr), .vol_code_l(vol_code_l), .vol_code_r(vol_code_r),
        .din_l(din_l), .din_r(din_r), .dout_l(dout_l), .dout_r(dout_r),
        .dout_valid(dout_valid)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int clampc(input int c);
        return (c > 60) ? 60 : c;
    endfunction

    // Expected scaled sample per R2 and R8.
    function automatic int scale(input int x, input int code);
        int c = clampc(code);
        int oct = c / 12;
        int r = c % 12;
        real mr = 16384.0 * (10.0 ** (r / 40.0));
        longint m = longint'($rtoi(mr + 0.5));
        int s = 16 - oct;
        longint p = longint'(x) * m + (longint'(1) <<< (s - 1));
        longint y = p >>> s;
        if (y > 32767) y = 32767;
        if (y < -32768) y = -32768;
        return int'(y);
    endfunction

    function automatic int step(input int cur, input int tgt);
        if (cur < tgt) return cur + 1;
        if (cur > tgt) return cur - 1;
        return cur;
    endfunction

    task automatic set_pwr(input bit p);
        dac_pwr = p;
        if (!p) begin cur_l = 24; cur_r = 24; end
        @(negedge clk);
    endtask

    // One strobe; checks the pair against the model, then steps the model.
    task automatic do_sample(input int xl, input int xr, input string tag);
        int tl = clampc(vol_code_l);
        int tr = clampc(link_lr ? vol_code_l : vol_code_r);
        din_l = 16'(xl);
        din_r = 16'(xr);
        sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
        check(dout_valid == 1'b1, {tag, " R7 valid"}, dout_valid, 1);
        check(dout_l == scale(xl, cur_l), {tag, " left"}, dout_l, scale(xl, cur_l));
        check(dout_r == scale(xr, cur_r), {tag, " right"}, dout_r, scale(xr, cur_r));
        if (dac_pwr) begin
            cur_l = step(cur_l, tl);
            cur_r = step(cur_r, tr);
        end
    endtask

    task automatic t_reset();
        check(dout_l == 0 && dout_r == 0, "R1 outputs zero", dout_l, 0);
        check(dout_valid == 0, "R1 valid low", dout_valid, 0);
        do_sample(12345, -12345, "R1 unity at start");
    endtask

    task automatic t_unpowered();
        vol_code_l = 8'h28;
        set_pwr(1'b0);
        for (int i = 0; i < 4; i++) do_sample(1000, -777, "R3 held unpowered");
        check(dout_l == 1000, "R3 unity", dout_l, 1000);
    endtask

    task automatic t_ramp_up();
        vol_code_l = 8'h28;
        link_lr = 1'b1;
        set_pwr(1'b1);
        for (int i = 0; i < 18; i++) do_sample(10000, 10000, "R4 ramp up");
        do_sample(10000, -10000, "R2 plus 8 dB");
        check(dout_l == 25178, "R2 +8dB value", dout_l, 25178);
    endtask

    task automatic t_no_strobe();
        logic signed [15:0] held = dout_l;
        repeat (20) @(negedge clk);
        check(dout_l == held, "R7 held between strobes", dout_l, held);
        check(dout_valid == 0, "R7 valid idle", dout_valid, 0);
        do_sample(5000, 5000, "R5 no step without strobe");
    endtask

    task automatic t_ramp_down();
        vol_code_l = 8'h10;
        for (int i = 0; i < 26; i++) do_sample(-20000, 20000, "R4 ramp down");
    endtask

    task automatic t_unlinked();
        link_lr = 1'b0;
        vol_code_l = 8'h14;
        vol_code_r = 8'h20;
        for (int i = 0; i < 20; i++) do_sample(9000, 9000, "R6 independent");
        check(dout_l != dout_r, "R6 channels differ", dout_l, dout_r);
        link_lr = 1'b1;
        for (int i = 0; i < 14; i++) do_sample(9000, 9000, "R6 relinked");
        check(dout_l == dout_r, "R6 linked equal", dout_r, dout_l);
    endtask

    task automatic t_clip_round();
        vol_code_l = 8'hFF;
        for (int i = 0; i < 60; i++) do_sample(100, -100, "R9 clamp ramp");
        do_sample(30000, -30000, "R8 clip");
        check(dout_l == 32767 && dout_r == -32768, "R8 clip limits", dout_l, 32767);
        vol_code_l = 8'h00;
        for (int i = 0; i < 62; i++) do_sample(3, -3, "R8 ramp to floor");
        do_sample(3, -3, "R8 round half up");
        check(dout_l == 1 && dout_r == -1, "R8 rounding", dout_l, 1);
        do_sample(2, -2, "R8 round half");
        check(dout_l == 1 && dout_r == 0, "R8 half case", dout_r, 0);
    endtask

    task automatic t_drop();
        vol_code_l = 8'h30;
        for (int i = 0; i < 30; i++) do_sample(4000, 4000, "R4 ramp again");
        set_pwr(1'b0);
        do_sample(4000, 4000, "R3 drop to unity");
        check(dout_l == 4000, "R3 unity after drop", dout_l, 4000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unpowered();
        t_ramp_up();
        t_no_strobe();
        t_ramp_down();
        t_unlinked();
        t_clip_round();
        t_drop();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule